// File: doc/BRIEF.md
# Shared-Prescaler Event Counter and Watchdog

This block pairs an 8-bit up-counter with a watchdog. One 8-bit prescaler serves both, and a 6-bit mode word decides which of the two receives it. The counter advances on instruction-cycle ticks or on a chosen edge of an external pin; it can be loaded at any time through its write port. The watchdog counts base ticks from a free-running on-chip oscillator and expires after `WDT_LIMIT` base ticks, stretched further by the prescaler when the prescaler is assigned to it.

The core uses two strobes to control the watchdog: one restarts it, and one enters sleep. The block keeps two status flags, timeout and power-loss, and together they record why the core last restarted. An expiry while awake produces a one-cycle core reset pulse. An expiry while asleep produces a one-cycle wake pulse instead. A master-clear input returns the mode word to its reset value and ends sleep.

Top module: `cycle_timer_wdog`

## Requirements
- R1: After `rst`, the mode word reads 0x3F, both flags read 1, the counter reads 0x00, and `asleep`, `wdt_rst` and `wake` are low.
- R2: A cycle with `mode_we` high loads `mode_wdata` into the mode word, which is visible on `mode_q` at the next edge. The fields are: bits 2:0 rate code, bit 3 prescaler owner (1 = watchdog), bit 4 pin edge (1 = falling), bit 5 count source (1 = external pin).
- R3: With bit 3 clear, the counter advances once per 2^(code+1) source events, so codes 0..7 give ratios 2 to 256.
- R4: With bit 3 set, the counter advances on every source event. The watchdog then expires after `WDT_LIMIT` × 2^code base ticks, so codes 0..7 give ratios 1 to 128.
- R5: With bit 5 set, `cyc_tick` is ignored and only the selected edge of `ext_pin` counts. The pin passes two synchronising flops, so the counter changes at the third rising clock edge after the pin changes.
- R6: The counter wraps from 0xFF to 0x00.
- R7: A counter write loads the value at the next edge and wins over a same-cycle increment. When bit 3 is clear, the write also empties the prescaler.
- R8: An expiry while awake drives `wdt_rst` high for one cycle at the edge after the expiring tick. At that same edge the mode word becomes 0x3F and the flags become timeout 0, power-loss 1.
- R9: An expiry while asleep gives no `wdt_rst`. It gives a one-cycle `wake` pulse, clears `asleep`, and sets both flags to 0.
- R10: `clr_wdt` restarts the watchdog count (and the prescaler when bit 3 is set) and sets both flags to 1. `sleep_req` performs the same restart, sets `asleep`, and sets timeout 1 and power-loss 0. A restart in the same cycle as an expiring tick suppresses that expiry.
- R11: `mclr` sets the mode word to 0x3F, clears `asleep` and restarts the watchdog, while the counter keeps its value. If the block was asleep, the flags become timeout 1, power-loss 0; otherwise they are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cyc_tick | input | 1 | Instruction-cycle enable |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_osc_tick | input | 1 | Base tick from the watchdog oscillator |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 6 | Mode word write data |
| mode_q | output | 6 | Current mode word |
| tmr_we | input | 1 | Counter write strobe |
| tmr_wdata | input | CNT_W | Counter write data |
| tmr_q | output | CNT_W | Counter value |
| clr_wdt | input | 1 | Restart watchdog strobe |
| sleep_req | input | 1 | Enter sleep strobe |
| mclr | input | 1 | Master-clear strobe |
| asleep | output | 1 | Sleep state |
| wdt_rst | output | 1 | One-cycle core reset on awake expiry |
| wake | output | 1 | One-cycle wake pulse on sleeping expiry |
| tmo_flag | output | 1 | Timeout status flag |
| pwr_flag | output | 1 | Power-loss status flag |

## Verification
A watchdog restart can land in the very cycle in which the last base tick would expire the watchdog. The bench provokes this by running the watchdog to one tick short of expiry, then raising `clr_wdt` and `wdt_osc_tick` together. It passes if no reset pulse follows, the flags read 1/1, and a full fresh `WDT_LIMIT` ticks are again needed before expiry. A counter write is also made to coincide with the prescaler carry. The bench judges that the written value survives and that the prescaler restarts empty.

// File: rtl/ctw_pkg.sv
package ctw_pkg;

    localparam int PRE_W  = 8;
    localparam int MODE_W = 6;
    localparam logic [MODE_W-1:0] MODE_RST = 6'h3F;

    typedef struct packed {
        logic       src_ext;    // 1: count pin edges
        logic       fall_edge;  // 1: falling edges count
        logic       pre_wdt;    // 1: prescaler serves watchdog
        logic [2:0] rate;       // divide code
    } mode_t;

    typedef struct packed {
        logic tmo;
        logic pwr;
    } flags_t;

    // terminal prescaler count for the given owner and code
    function automatic logic [PRE_W-1:0] pre_limit(input logic to_wdt, input logic [2:0] rate);
        logic [PRE_W:0] span;
        span = (PRE_W+1)'(1) << rate;
        if (!to_wdt)
            span = span << 1;
        return PRE_W'(span - (PRE_W+1)'(1));
    endfunction

endpackage

// File: rtl/ctw_edge_sync.sv
module ctw_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-1:0], pin};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/ctw_prescaler.sv
module ctw_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         evt,
    input  logic [W-1:0] limit,
    output logic         carry
);
    logic [W-1:0] cnt;

    // >= keeps a shortened ratio safe after a mode change
    assign carry = evt && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (evt)
            cnt <= carry ? '0 : cnt + W'(1);
    end
endmodule

// File: rtl/ctw_wdt_base.sv
module ctw_wdt_base #(
    parameter int LIMIT = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic ovf
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign ovf = tick && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= ovf ? '0 : cnt + CW'(1);
    end
endmodule

// File: rtl/cycle_timer_wdog.sv
module cycle_timer_wdog
    import ctw_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int WDT_LIMIT   = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_tick,
    input  logic              ext_pin,
    input  logic              wdt_osc_tick,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic [MODE_W-1:0] mode_q,
    input  logic              tmr_we,
    input  logic [CNT_W-1:0]  tmr_wdata,
    output logic [CNT_W-1:0]  tmr_q,
    input  logic              clr_wdt,
    input  logic              sleep_req,
    input  logic              mclr,
    output logic              asleep,
    output logic              wdt_rst,
    output logic              wake,
    output logic              tmo_flag,
    output logic              pwr_flag
);
    mode_t            mode_r;
    flags_t           flags_r;
    logic             asleep_r, wdt_rst_r, wake_r;
    logic [CNT_W-1:0] tmr_r;

    logic pin_rise, pin_fall, pin_evt, src_evt;
    logic base_ovf, pre_evt, pre_clr, pre_carry;
    logic tmr_inc, wdt_restart, expire, core_rst;

    ctw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_pin),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign pin_evt = mode_r.fall_edge ? pin_fall : pin_rise;
    assign src_evt = mode_r.src_ext ? pin_evt : cyc_tick;

    assign wdt_restart = clr_wdt | sleep_req | mclr;

    ctw_wdt_base #(.LIMIT(WDT_LIMIT)) u_base (
        .clk  (clk),
        .rst  (rst),
        .clr  (wdt_restart),
        .tick (wdt_osc_tick),
        .ovf  (base_ovf)
    );

    assign pre_evt = mode_r.pre_wdt ? base_ovf : src_evt;
    assign expire  = (mode_r.pre_wdt ? pre_carry : base_ovf) & ~wdt_restart;
    assign core_rst = expire & ~asleep_r;
    assign pre_clr = mclr | core_rst |
                     (mode_r.pre_wdt ? (clr_wdt | sleep_req) : tmr_we);

    ctw_prescaler #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (pre_clr),
        .evt   (pre_evt),
        .limit (pre_limit(mode_r.pre_wdt, mode_r.rate)),
        .carry (pre_carry)
    );

    assign tmr_inc = mode_r.pre_wdt ? src_evt : pre_carry;

    always_ff @(posedge clk) begin
        if (rst)
            tmr_r <= '0;
        else if (tmr_we)
            tmr_r <= tmr_wdata;
        else if (tmr_inc)
            tmr_r <= tmr_r + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r    <= mode_t'(MODE_RST);
            flags_r   <= '{tmo: 1'b1, pwr: 1'b1};
            asleep_r  <= 1'b0;
            wdt_rst_r <= 1'b0;
            wake_r    <= 1'b0;
        end else begin
            wdt_rst_r <= core_rst;
            wake_r    <= expire & asleep_r;
            if (mclr) begin
                mode_r   <= mode_t'(MODE_RST);
                asleep_r <= 1'b0;
                if (asleep_r)
                    flags_r <= '{tmo: 1'b1, pwr: 1'b0};
            end else if (expire) begin
                asleep_r <= 1'b0;
                if (asleep_r) begin
                    flags_r <= '{tmo: 1'b0, pwr: 1'b0};
                end else begin
                    flags_r <= '{tmo: 1'b0, pwr: 1'b1};
                    mode_r  <= mode_t'(MODE_RST);
                end
            end else begin
                if (mode_we)
                    mode_r <= mode_t'(mode_wdata);
                if (sleep_req) begin
                    asleep_r <= 1'b1;
                    flags_r  <= '{tmo: 1'b1, pwr: 1'b0};
                end else if (clr_wdt) begin
                    flags_r  <= '{tmo: 1'b1, pwr: 1'b1};
                end
            end
        end
    end

    assign mode_q   = mode_r;
    assign tmr_q    = tmr_r;
    assign asleep   = asleep_r;
    assign wdt_rst  = wdt_rst_r;
    assign wake     = wake_r;
    assign tmo_flag = flags_r.tmo;
    assign pwr_flag = flags_r.pwr;
endmodule

// File: rtl/ctw_checker.sv
module ctw_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mclr,
    input logic             clr_wdt,
    input logic             sleep_req,
    input logic             tmr_we,
    input logic [CNT_W-1:0] tmr_wdata,
    input logic [CNT_W-1:0] tmr_q,
    input logic [5:0]       mode_q,
    input logic             tmo_flag,
    input logic             pwr_flag,
    input logic             asleep,
    input logic             wdt_rst,
    input logic             wake
);
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (rst)
        tmr_we |=> tmr_q == $past(tmr_wdata));

    assert_step_or_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !tmr_we |=> (tmr_q == $past(tmr_q)) || (tmr_q == $past(tmr_q) + CNT_W'(1)));

    assert_reset_cause_R8: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> (mode_q == 6'h3F) && !tmo_flag && pwr_flag);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

    assert_wake_cause_R9: assert property (@(posedge clk) disable iff (rst)
        wake |-> !tmo_flag && !pwr_flag && !asleep);

    assert_awake_only_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wdt_rst, wake}));

    assert_sleep_entry_R10: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && !mclr) |=> asleep && tmo_flag && !pwr_flag);

    assert_restart_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_wdt && !sleep_req && !mclr) |=> tmo_flag && pwr_flag);

    assert_mclr_mode_R11: assert property (@(posedge clk) disable iff (rst)
        mclr |=> (mode_q == 6'h3F) && !asleep);
endmodule

bind cycle_timer_wdog ctw_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mclr      (mclr),
    .clr_wdt   (clr_wdt),
    .sleep_req (sleep_req),
    .tmr_we    (tmr_we),
    .tmr_wdata (tmr_wdata),
    .tmr_q     (tmr_q),
    .mode_q    (mode_q),
    .tmo_flag  (tmo_flag),
    .pwr_flag  (pwr_flag),
    .asleep    (asleep),
    .wdt_rst   (wdt_rst),
    .wake      (wake)
);

// File: tb/cycle_timer_wdog_test.sv
module cycle_timer_wdog_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_tick = 1'b0, ext_pin = 1'b0, wdt_osc_tick = 1'b0;
    logic       mode_we = 1'b0, tmr_we = 1'b0;
    logic [5:0] mode_wdata = '0;
    logic [7:0] tmr_wdata = '0;
    logic       clr_wdt = 1'b0, sleep_req = 1'b0, mclr = 1'b0;
    logic [5:0] mode_q;
    logic [7:0] tmr_q;
    logic       asleep, wdt_rst, wake, tmo_flag, pwr_flag;

    int n_chk = 0, n_fail = 0, n_rst = 0, n_wake = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cycle_timer_wdog #(.CNT_W(8), .SYNC_STAGES(2), .WDT_LIMIT(LIMIT)) uut (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
        .wdt_osc_tick(wdt_osc_tick), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .mode_q(mode_q), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .tmr_q(tmr_q),
        .clr_wdt(clr_wdt), .sleep_req(sleep_req), .mclr(mclr), .asleep(asleep),
        .wdt_rst(wdt_rst), .wake(wake), .tmo_flag(tmo_flag), .pwr_flag(pwr_flag)
    );

    always @(negedge clk) begin
        if (wdt_rst) n_rst++;
        if (wake)    n_wake++;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // all tasks start and end just after a falling edge
    task automatic write_mode(input logic [5:0] m);
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic write_tmr(input logic [7:0] v);
        tmr_we = 1'b1; tmr_wdata = v;
        @(negedge clk);
        tmr_we = 1'b0;
    endtask

    task automatic ticks_cyc(input int n);
        if (n > 0) begin
            cyc_tick = 1'b1;
            repeat (n) @(negedge clk);
            cyc_tick = 1'b0;
        end
    endtask

    task automatic ticks_wdt(input int n);
        if (n > 0) begin
            wdt_osc_tick = 1'b1;
            repeat (n) @(negedge clk);
            wdt_osc_tick = 1'b0;
        end
    endtask

    task automatic strobe_clr();
        clr_wdt = 1'b1; @(negedge clk); clr_wdt = 1'b0;
    endtask

    task automatic strobe_sleep();
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic strobe_mclr();
        mclr = 1'b1; @(negedge clk); mclr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 mode", mode_q, 8'h3F);
        check("R1 tmo", tmo_flag, 1);
        check("R1 pwr", pwr_flag, 1);
        check("R1 counter", tmr_q, 0);
        check("R1 pulses", {asleep, wdt_rst, wake}, 0);

        // R2 mode load
        write_mode(6'h2A);
        check("R2 mode 2A", mode_q, 8'h2A);
        write_mode(6'h15);
        check("R2 mode 15", mode_q, 8'h15);

        // R3 counter-owned prescaler, every code
        for (int ps = 0; ps < 8; ps++) begin
            int r;
            r = 2 << ps;
            write_mode(6'(ps));
            write_tmr(8'h00);
            ticks_cyc(r * 3 + r - 1);
            check($sformatf("R3 code %0d partial", ps), tmr_q, 3);
            ticks_cyc(1);
            check($sformatf("R3 code %0d carry", ps), tmr_q, 4);
        end

        // R4 bypass when watchdog owns the prescaler
        write_mode(6'h0F);
        write_tmr(8'h00);
        ticks_cyc(5);
        check("R4 bypass count", tmr_q, 5);

        // R6 wrap
        write_tmr(8'hFE);
        ticks_cyc(3);
        check("R6 wrap", tmr_q, 1);

        // R7 write collides with prescaler carry
        write_mode(6'h00);
        write_tmr(8'h00);
        ticks_cyc(1);
        cyc_tick = 1'b1; tmr_we = 1'b1; tmr_wdata = 8'h10;
        @(negedge clk);
        cyc_tick = 1'b0; tmr_we = 1'b0;
        check("R7 write wins", tmr_q, 8'h10);
        ticks_cyc(1);
        check("R7 prescaler emptied", tmr_q, 8'h10);
        ticks_cyc(1);
        check("R7 first carry", tmr_q, 8'h11);

        // R5 external pin, rising then falling
        write_mode(6'h28);
        write_tmr(8'h00);
        ext_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R5 sync latency", tmr_q, 0);
        @(negedge clk);
        check("R5 rising counted", tmr_q, 1);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 falling ignored", tmr_q, 1);
        write_mode(6'h38);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 rising ignored", tmr_q, 1);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 falling counted", tmr_q, 2);
        ticks_cyc(5);
        check("R5 cycle ticks ignored", tmr_q, 2);

        // R4 and R8 watchdog expiry, every code
        for (int ps = 0; ps < 8; ps++) begin
            int r;
            r = 1 << ps;
            write_mode(6'h08 | 6'(ps));
            strobe_clr();
            base = n_rst;
            ticks_wdt(LIMIT * r - 1);
            @(negedge clk);
            check($sformatf("R4 code %0d early", ps), n_rst, base);
            ticks_wdt(1);
            @(negedge clk);
            check($sformatf("R4 code %0d expiry", ps), n_rst, base + 1);
            check("R8 mode restored", mode_q, 8'h3F);
            check("R8 flags", {tmo_flag, pwr_flag}, 1);
        end

        // R11 master-clear while awake
        write_tmr(8'h77);
        write_mode(6'h15);
        strobe_mclr();
        check("R11 mode", mode_q, 8'h3F);
        check("R11 flags kept", {tmo_flag, pwr_flag}, 1);
        check("R11 counter kept", tmr_q, 8'h77);

        // R10 restart collides with expiring tick
        write_mode(6'h08);
        strobe_clr();
        check("R10 clr flags", {tmo_flag, pwr_flag}, 3);
        base = n_rst;
        ticks_wdt(LIMIT - 1);
        wdt_osc_tick = 1'b1; clr_wdt = 1'b1;
        @(negedge clk);
        wdt_osc_tick = 1'b0; clr_wdt = 1'b0;
        @(negedge clk);
        check("R10 expiry suppressed", n_rst, base);
        ticks_wdt(LIMIT - 1);
        @(negedge clk);
        check("R10 count restarted", n_rst, base);
        ticks_wdt(1);
        @(negedge clk);
        check("R10 later expiry", n_rst, base + 1);

        // R9 expiry during sleep
        write_mode(6'h08);
        strobe_sleep();
        check("R10 sleep state", {asleep, tmo_flag, pwr_flag}, 6);
        base = n_rst;
        ticks_wdt(LIMIT);
        @(negedge clk);
        check("R9 wake pulse", n_wake, 1);
        check("R9 no reset", n_rst, base);
        check("R9 state", {asleep, tmo_flag, pwr_flag}, 0);
        check("R9 mode kept", mode_q, 8'h08);

        // R11 master-clear during sleep
        strobe_sleep();
        strobe_mclr();
        check("R11 sleep ended", asleep, 0);
        check("R11 sleep flags", {tmo_flag, pwr_flag}, 2);
        check("R11 mode after sleep", mode_q, 8'h3F);

        summary();
        $finish;
    end
endmodule